// File: doc/BRIEF.md
# Carrier-Aided Code NCO Update Scheduler

This block drives the code numerically controlled oscillator of a spreading-code tracking loop whose rate is steered by the carrier loop. Each carrier-loop iteration raises a one-cycle update strobe. The strobe carries one code discriminator sample, the current carrier frequency word and the aiding scale.

The discriminator samples are summed over a programmable block of carrier iterations. When a block is complete, a first-order code filter scales the block sum with an arithmetic right shift. The result is held until the next block completes. This lowers the code-filter rate and the noise without lengthening any correlation interval.

The code rate word is rewritten on every carrier strobe, whether or not a new filter output exists. Each rewrite takes the held filter output and adds a fresh aiding term, the carrier frequency scaled to chip rate. A 32-bit phase accumulator adds the rate word on every clock and pulses a chip strobe when it wraps.

Top module: `code_nco_sched`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `rate_word`, `nco_phase` and `chip_stb` are all zero.
- R2: The block length is `blk_len` clamped to the range 1 to `blk_max`. A `blk_len` of 0 counts as 1, a `blk_max` of 0 counts as 1, and a `blk_len` above `blk_max` is replaced by `blk_max`. Each `carr_upd` adds the signed `disc_in` to the running block sum. The clamp is evaluated at every strobe.
- R3: When a strobe is the last one of a block, the filter output becomes (block sum including this sample) arithmetically shifted right by `gain_shift`, which rounds toward minus infinity. The running sum and the strobe count then restart from zero.
- R4: Between block completions the filter output is held. It is zero from reset until the first block completes.
- R5: On each `carr_upd` edge, `rate_word` becomes (filter output, including a block completing on that strobe) + aiding term, taken modulo 2^32. It is unchanged on clocks without `carr_upd`.
- R6: The aiding term is floor(signed `carr_freq` × unsigned `aid_scale` / 2^16). `aid_scale` is a fixed-point value with 16 fractional bits.
- R7: On every clock, `nco_phase` takes the value (`nco_phase` + `rate_word`) modulo 2^32, using the values present before that edge.
- R8: `chip_stb` is high in exactly those cycles whose `nco_phase` resulted from a sum of 2^32 or more, which is a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carr_upd | input | 1 | One-cycle strobe per carrier-loop iteration |
| disc_in | input | 16 | Signed code discriminator sample, valid with the strobe |
| carr_freq | input | 32 | Signed carrier frequency word, sampled at the strobe |
| aid_scale | input | 16 | Unsigned aiding scale, 16 fractional bits |
| blk_len | input | 8 | Requested number of strobes per filter block |
| blk_max | input | 8 | Upper cap on the block length |
| gain_shift | input | 5 | Filter gain as a right-shift count |
| rate_word | output | 32 | Code NCO rate word |
| nco_phase | output | 32 | Code NCO phase |
| chip_stb | output | 1 | One-cycle pulse on each phase wrap |

## Verification
The bench builds the block with its default parameters: 16-bit samples, an 8-bit block counter and a 32-bit phase. With these values, block lengths up to 255 and a cap below the requested length can both be exercised. The 32-bit signed frequency range makes rate words that wrap the phase within a few cycles, so chip strobes, negative filter sums and floor rounding of negative aiding products all occur in a short run. Block length and cap change in the middle of a block, which exercises clamping evaluated at every strobe.

// File: rtl/cn_pkg.sv
package cn_pkg;
  // Block length after clamping: zero counts as one, cap applies last.
  function automatic logic [15:0] cn_eff_len(input logic [15:0] len, input logic [15:0] cap);
    logic [15:0] l;
    logic [15:0] c;
    l = (len == 16'd0) ? 16'd1 : len;
    c = (cap == 16'd0) ? 16'd1 : cap;
    return (l > c) ? c : l;
  endfunction
endpackage

// File: rtl/cn_blk_accum.sv
module cn_blk_accum #(
  parameter int DISC_W = 16,
  parameter int CNT_W  = 8,
  parameter int SH_W   = 5,
  localparam int SUM_W = DISC_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [DISC_W-1:0] disc,
  input  logic [CNT_W-1:0]  blk_len,
  input  logic [CNT_W-1:0]  blk_max,
  input  logic [SH_W-1:0]   gain_sh,
  output logic [SUM_W-1:0]  filt_sel
);
  import cn_pkg::*;

  function automatic logic signed [SUM_W-1:0] f_filter(input logic signed [SUM_W-1:0] s,
                                                      input logic [SH_W-1:0] sh);
    return s >>> sh;
  endfunction

  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] sum_nx;
  logic [SUM_W-1:0] filt_q;
  logic [SUM_W-1:0] filt_new;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      eff;
  logic             blk_done;
  logic             seen_q;

  always_comb begin
    sum_nx   = sum_q + {{CNT_W{disc[DISC_W-1]}}, disc};
    eff      = cn_eff_len(16'(blk_len), 16'(blk_max));
    blk_done = upd && ((16'(cnt_q) + 16'd1) >= eff);
    filt_new = f_filter(sum_nx, gain_sh);
    filt_sel = blk_done ? filt_new : filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      filt_q <= '0;
      seen_q <= 1'b0;
    end else if (upd) begin
      if (blk_done) begin
        sum_q  <= '0;
        cnt_q  <= '0;
        filt_q <= filt_new;
        seen_q <= 1'b1;
      end else begin
        sum_q <= sum_nx;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (sum_q == '0 && cnt_q == '0));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_done |=> $stable(filt_q));
  assert_zero_until_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> filt_q == '0);
endmodule

// File: rtl/cn_aid_mix.sv
module cn_aid_mix #(
  parameter int FREQ_W   = 32,
  parameter int SCALE_W  = 16,
  parameter int AID_FRAC = 16,
  parameter int FILT_W   = 24,
  parameter int RATE_W   = 32,
  localparam int PROD_W  = FREQ_W + SCALE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic [FREQ_W-1:0]  carr_freq,
  input  logic [SCALE_W-1:0] aid_scale,
  input  logic [FILT_W-1:0]  filt_sel,
  output logic [RATE_W-1:0]  rate_q
);
  function automatic logic signed [PROD_W-1:0] f_aid(input logic signed [FREQ_W-1:0] f,
                                                     input logic [SCALE_W-1:0] s);
    logic signed [PROD_W-1:0] p;
    p = f * $signed({1'b0, s});
    return p >>> AID_FRAC;
  endfunction

  logic signed [PROD_W-1:0] aid_full;
  logic [RATE_W-1:0]        rate_nx;

  always_comb begin
    aid_full = f_aid(carr_freq, aid_scale);
    rate_nx  = aid_full[RATE_W-1:0] + {{(RATE_W-FILT_W){filt_sel[FILT_W-1]}}, filt_sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rate_q <= '0;
    else if (upd) rate_q <= rate_nx;
  end

  assert_rate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(rate_q));
endmodule

// File: rtl/cn_phase_acc.sv
module cn_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] rate,
  output logic [PHASE_W-1:0] phase_q,
  output logic               wrap_q
);
  logic [PHASE_W:0] sum_ext;

  always_comb sum_ext = {1'b0, phase_q} + {1'b0, rate};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      phase_q <= sum_ext[PHASE_W-1:0];
      wrap_q  <= sum_ext[PHASE_W];
    end
  end

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> phase_q < $past(phase_q));
  assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_q |-> phase_q >= $past(phase_q));
endmodule

// File: rtl/code_nco_sched.sv
module code_nco_sched #(
  parameter int DISC_W   = 16,
  parameter int CNT_W    = 8,
  parameter int SH_W     = 5,
  parameter int FREQ_W   = 32,
  parameter int SCALE_W  = 16,
  parameter int AID_FRAC = 16,
  parameter int PHASE_W  = 32,
  localparam int SUM_W   = DISC_W + CNT_W,
  localparam int RATE_W  = PHASE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               carr_upd,
  input  logic [DISC_W-1:0]  disc_in,
  input  logic [FREQ_W-1:0]  carr_freq,
  input  logic [SCALE_W-1:0] aid_scale,
  input  logic [CNT_W-1:0]   blk_len,
  input  logic [CNT_W-1:0]   blk_max,
  input  logic [SH_W-1:0]    gain_shift,
  output logic [RATE_W-1:0]  rate_word,
  output logic [PHASE_W-1:0] nco_phase,
  output logic               chip_stb
);
  logic [SUM_W-1:0] filt_sel;

  cn_blk_accum #(.DISC_W(DISC_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .upd(carr_upd), .disc(disc_in),
    .blk_len(blk_len), .blk_max(blk_max), .gain_sh(gain_shift),
    .filt_sel(filt_sel)
  );

  cn_aid_mix #(.FREQ_W(FREQ_W), .SCALE_W(SCALE_W), .AID_FRAC(AID_FRAC),
               .FILT_W(SUM_W), .RATE_W(RATE_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .upd(carr_upd), .carr_freq(carr_freq),
    .aid_scale(aid_scale), .filt_sel(filt_sel), .rate_q(rate_word)
  );

  cn_phase_acc #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .rate(rate_word),
    .phase_q(nco_phase), .wrap_q(chip_stb)
  );
endmodule

// File: tb/test_code_nco_sched.sv
module test_code_nco_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        carr_upd = 1'b0;
  logic [15:0] disc_in = '0;
  logic [31:0] carr_freq = '0;
  logic [15:0] aid_scale = '0;
  logic [7:0]  blk_len = 8'd1;
  logic [7:0]  blk_max = 8'd1;
  logic [4:0]  gain_shift = '0;
  logic [31:0] rate_word;
  logic [31:0] nco_phase;
  logic        chip_stb;

  int n_chk = 0;
  int n_fail = 0;
  int n_wraps = 0;
  string cur_req = "R5";
  bit done = 0;

  // bench-side reference state
  longint m_sum = 0, m_filt = 0, m_rate = 0, m_phase = 0;
  int m_cnt = 0;
  bit m_stb = 0;
  localparam longint MASK32 = 64'hFFFF_FFFF;

  always #4 clk = ~clk;

  code_nco_sched i_code_nco_sched (
    .clk(clk), .rst_n(rst_n), .carr_upd(carr_upd), .disc_in(disc_in),
    .carr_freq(carr_freq), .aid_scale(aid_scale), .blk_len(blk_len),
    .blk_max(blk_max), .gain_shift(gain_shift), .rate_word(rate_word),
    .nco_phase(nco_phase), .chip_stb(chip_stb)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sum = 0; m_filt = 0; m_rate = 0; m_phase = 0; m_cnt = 0; m_stb = 0;
    end else begin
      longint np;
      np = m_phase + m_rate;
      m_stb = (np >= 64'h1_0000_0000);
      m_phase = np & MASK32;
      if (carr_upd) begin
        int l, c;
        longint s, aid;
        l = (blk_len == 0) ? 1 : int'(blk_len);
        c = (blk_max == 0) ? 1 : int'(blk_max);
        if (l > c) l = c;
        s = m_sum + longint'($signed(disc_in));
        if (m_cnt + 1 >= l) begin
          m_filt = s >>> gain_shift;
          m_sum = 0; m_cnt = 0;
        end else begin
          m_sum = s; m_cnt = m_cnt + 1;
        end
        aid = (longint'($signed(carr_freq)) * longint'(aid_scale)) >>> 16;
        m_rate = (m_filt + aid) & MASK32;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rate_word == m_rate[31:0], cur_req, longint'(rate_word), m_rate);
      chk(nco_phase == m_phase[31:0], "R7", longint'(nco_phase), m_phase);
      chk(chip_stb == m_stb, "R8", longint'(chip_stb), longint'(m_stb));
      if (chip_stb) n_wraps++;
    end
  end

  task automatic strobe(input int d);
    carr_upd = 1'b1;
    disc_in = 16'(d);
    @(negedge clk);
    carr_upd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(2);
    // R1: outputs at zero during reset
    chk(rate_word == 0 && nco_phase == 0 && chip_stb == 0, "R1", longint'(rate_word), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rate_word == 0 && nco_phase == 0 && chip_stb == 0, "R1", longint'(nco_phase), 0);

    // R4: no filter output before first block; aiding off
    cur_req = "R4";
    blk_len = 8'd4; blk_max = 8'd8; gain_shift = 5'd0; aid_scale = 0; carr_freq = 32'd1000;
    strobe(7); idle(1); strobe(5); strobe(-2);
    chk(rate_word == 0, "R4", longint'(rate_word), 0);
    strobe(10);
    chk(rate_word == 32'd20, "R3", longint'(rate_word), 20);
    idle(3);
    chk(rate_word == 32'd20, "R4", longint'(rate_word), 20);

    // R3: negative sum, floor shift
    cur_req = "R3";
    blk_len = 8'd2; gain_shift = 5'd1;
    strobe(-5); strobe(-6);
    chk(rate_word == 32'hFFFF_FFFA, "R3", longint'(rate_word), 64'hFFFF_FFFA);

    // R5: held filter plus fresh aiding on every strobe
    cur_req = "R5";
    aid_scale = 16'h0001; carr_freq = 32'h0003_0000;
    strobe(100);
    chk(rate_word == 32'd3 - 32'd6, "R5", longint'(rate_word), 64'hFFFF_FFFD);
    carr_freq = 32'h0010_0000;
    strobe(0);
    chk(rate_word == 32'd16 + 32'd50, "R5", longint'(rate_word), 66);

    // R2: cap below requested length, and zero length
    cur_req = "R2";
    aid_scale = 0; gain_shift = 0; blk_len = 8'd1;
    strobe(0);
    blk_len = 8'd10; blk_max = 8'd3;
    strobe(1); strobe(1);
    chk(rate_word == 0, "R2", longint'(rate_word), 0);
    strobe(1);
    chk(rate_word == 32'd3, "R2", longint'(rate_word), 3);
    blk_len = 8'd0;
    strobe(9);
    chk(rate_word == 32'd9, "R2", longint'(rate_word), 9);
    blk_len = 8'd5; blk_max = 8'd0;
    strobe(-4);
    chk(rate_word == 32'hFFFF_FFFC, "R2", longint'(rate_word), 64'hFFFF_FFFC);

    // R6: negative fractional aiding rounds down
    cur_req = "R6";
    blk_max = 8'd1;
    strobe(0);
    carr_freq = 32'hFFFF_FFFD; aid_scale = 16'h8000;
    strobe(0);
    chk(rate_word == 32'hFFFF_FFFE, "R6", longint'(rate_word), 64'hFFFF_FFFE);
    carr_freq = 32'd1_000_000; aid_scale = 16'h1234;
    strobe(0);
    chk(rate_word == 32'((64'd1_000_000 * 64'h1234) >> 16), "R6", longint'(rate_word),
        longint'((64'd1_000_000 * 64'h1234) >> 16));

    // R7/R8: large rate, wraps
    cur_req = "R5";
    carr_freq = 32'h7000_0000; aid_scale = 16'hFFFF;
    strobe(0);
    idle(20);
    chk(n_wraps > 0, "R8", longint'(n_wraps), 1);

    // random traffic, mid-block config changes
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        blk_len = 8'($urandom_range(0, 12));
        blk_max = 8'($urandom_range(0, 12));
        gain_shift = 5'($urandom_range(0, 31));
        aid_scale = 16'($urandom);
        carr_freq = $urandom;
      end
      if ($urandom_range(0, 2) != 0) strobe(int'($signed(16'($urandom))));
      else idle(1);
    end
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule